// File: doc/BRIEF.md
# Receive Header Checker

This block sits after the acquisition front end of a direct-sequence receiver. It takes descrambled bits, one on each cycle where a valid strobe is high. A start pulse arms it once the descrambler has initialised. It then searches a 16-bit sliding window for either of two start-of-frame patterns, and the pattern that matches tells it whether the frame uses the long or the short preamble. The search is bounded by a bit-count timeout. The timeout limit is picked from the polarity of the first sync bit: long sync is all ones and short sync is all zeros.

After the delimiter, the block captures a 48-bit header. This header holds an 8-bit rate code, an 8-bit service byte, a 16-bit length and a 16-bit CRC. The block checks the CRC against its own CRC-16 over the first 32 bits. On a match it raises a ready level and presents the parsed fields. These include a 2-bit rate selection for the demodulator and two service flags. On a mismatch it sets a sticky error flag, keeps ready low and drops back to idle. An expired search also drops back to idle, with a one-cycle timeout pulse and no error flag.

Top module: `hdr_rx_check`

## Requirements
- R1: After reset, hdr_ready, crc_err, sfd_tmo, fmt_short and all field outputs are 0.
- R2: The search is armed only by start. In the idle state, bits are ignored, and a complete valid frame sent without start leaves hdr_ready at 0.
- R3: A delimiter is detected when the last 16 accepted bits, oldest first, read 0x05CF (long format, fmt_short=0) or 0xF3A0 (short format, fmt_short=1). Only bits received since start count toward the window.
- R4: The first bit after start selects the timeout: 1 selects tmo_long, 0 selects tmo_short. sfd_tmo pulses for one cycle after the accepted bit whose count equals the limit if that bit does not complete a delimiter. A delimiter completed on that bit is accepted.
- R5: A timeout returns the block to idle without setting crc_err.
- R6: The header fields follow the delimiter, each sent LSB first: rate code, service, length, in that order. The 16-bit CRC follows them, MSB first.
- R7: The CRC is preset to 0xFFFF and uses polynomial 0x1021 over the 32 field bits in order received. It is complemented before comparison. On a match, hdr_ready goes to 1 one cycle after the last CRC bit, and sig_field, svc_field and len_field show the captured values.
- R8: On a mismatch, crc_err goes to 1, hdr_ready stays 0 and the block returns to idle.
- R9: crc_err stays 1 across later frames until err_clr is high for a cycle.
- R10: rate is 0 for code 0x0A, 1 for 0x14, 2 for 0x37, 3 for 0x6E, and 0 for any other code.
- R11: len_ext equals service bit 7 and osc_locked equals service bit 2 of the accepted header.
- R12: Cycles with bit_vld low do not advance the search or the header capture.
- R13: A start pulse clears hdr_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms the delimiter search |
| bit_vld | input | 1 | bit_in is valid this cycle |
| bit_in | input | 1 | Descrambled receive bit |
| tmo_long | input | TW | Search limit in bits, long format |
| tmo_short | input | TW | Search limit in bits, short format |
| err_clr | input | 1 | Write-one-to-clear for crc_err |
| hdr_ready | output | 1 | Header accepted |
| fmt_short | output | 1 | Last delimiter was the short pattern |
| sfd_tmo | output | 1 | One-cycle search timeout pulse |
| crc_err | output | 1 | Sticky header CRC error |
| sig_field | output | 8 | Captured rate code |
| svc_field | output | 8 | Captured service byte |
| len_field | output | 16 | Captured length |
| rate | output | 2 | Demodulator rate selection |
| len_ext | output | 1 | Length extension flag |
| osc_locked | output | 1 | Locked-clocks flag |

## Verification
Every result is a register loaded on the edge that accepts the deciding bit: the last CRC bit for hdr_ready, crc_err and the fields, the limit-th search bit for sfd_tmo, and the delimiter's last bit for fmt_short. Each result is therefore visible one clock edge after that bit is accepted. The bench drives each bit on a falling edge and samples on the next falling edge, so it observes every result in the first half-cycle where it is due. For the timeout, the bench samples after the bit one before the limit and again after the limit bit, which pins the pulse to one exact edge.

// File: rtl/hdr_rx_check.sv
module hdr_rx_check #(
  parameter int TW = 10,
  parameter logic [15:0] LONG_SFD = 16'h05CF,
  parameter logic [15:0] SHORT_SFD = 16'hF3A0,
  parameter logic [15:0] CRC_POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic [TW-1:0] tmo_long,
  input  logic [TW-1:0] tmo_short,
  input  logic          err_clr,
  output logic          hdr_ready,
  output logic          fmt_short,
  output logic          sfd_tmo,
  output logic          crc_err,
  output logic [7:0]    sig_field,
  output logic [7:0]    svc_field,
  output logic [15:0]   len_field,
  output logic [1:0]    rate,
  output logic          len_ext,
  output logic          osc_locked
);
  localparam int FLD_BITS = 32;
  localparam int HDR_BITS = FLD_BITS + 16;
  localparam int HW = $clog2(HDR_BITS);

  typedef enum logic [1:0] {IDLE, SRCH, HDR} st_t;
  st_t st;

  logic [TW-1:0] scnt;
  logic [15:0]   win, crc, rcrc;
  logic [FLD_BITS-1:0] fld;
  logic [HW-1:0] hcnt;
  logic          sel_long;

  wire [TW-1:0] scnt_nx = scnt + 1'b1;
  wire [15:0]   win_nx  = {win[14:0], bit_in};
  wire          full    = scnt_nx >= TW'(16);
  wire          hit_l   = full && (win_nx == LONG_SFD);
  wire          hit_s   = full && (win_nx == SHORT_SFD);
  wire          use_l   = (scnt == '0) ? bit_in : sel_long;
  wire [TW-1:0] limit   = use_l ? tmo_long : tmo_short;
  wire          fb      = bit_in ^ crc[15];
  wire [15:0]   crc_nx  = {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  wire [15:0]   rcrc_nx = {rcrc[14:0], bit_in};
  wire          crc_ok  = rcrc_nx == ~crc;

  function automatic logic [1:0] rate_of(input logic [7:0] code);
    case (code)
      8'h14:   return 2'd1;
      8'h37:   return 2'd2;
      8'h6E:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      scnt <= '0;
      win <= '0;
      crc <= '1;
      rcrc <= '0;
      fld <= '0;
      hcnt <= '0;
      sel_long <= 1'b0;
      hdr_ready <= 1'b0;
      fmt_short <= 1'b0;
      sfd_tmo <= 1'b0;
      crc_err <= 1'b0;
      sig_field <= '0;
      svc_field <= '0;
      len_field <= '0;
      rate <= '0;
      len_ext <= 1'b0;
      osc_locked <= 1'b0;
    end else begin
      sfd_tmo <= 1'b0;
      if (err_clr) crc_err <= 1'b0;
      if (start) begin
        st <= SRCH;
        scnt <= '0;
        hdr_ready <= 1'b0;
      end else if (bit_vld) begin
        case (st)
          SRCH: begin
            scnt <= scnt_nx;
            win <= win_nx;
            if (scnt == '0) sel_long <= bit_in;
            if (hit_l || hit_s) begin
              st <= HDR;
              fmt_short <= hit_s;
              hcnt <= '0;
              crc <= '1;
            end else if (scnt_nx == limit) begin
              st <= IDLE;
              sfd_tmo <= 1'b1;
            end
          end
          HDR: begin
            hcnt <= hcnt + 1'b1;
            if (hcnt < HW'(FLD_BITS)) begin
              fld <= {bit_in, fld[FLD_BITS-1:1]};
              crc <= crc_nx;
            end else begin
              rcrc <= rcrc_nx;
            end
            if (hcnt == HW'(HDR_BITS - 1)) begin
              st <= IDLE;
              if (crc_ok) begin
                hdr_ready <= 1'b1;
                sig_field <= fld[7:0];
                svc_field <= fld[15:8];
                len_field <= fld[31:16];
                rate <= rate_of(fld[7:0]);
                len_ext <= fld[15];
                osc_locked <= fld[10];
              end else begin
                hdr_ready <= 1'b0;
                crc_err <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r7_ready_from_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_ready) |-> $past(st) == HDR);
  a_r5_tmo_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_tmo |-> !$rose(crc_err) && !hdr_ready);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !err_clr |=> crc_err);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE && !start |=> st == IDLE);
  a_r4_tmo_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_tmo |=> !sfd_tmo);
  a_r8_err_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> !hdr_ready);
  a_r13_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !hdr_ready);
endmodule

// File: tb/hdr_rx_check_bench.sv
module hdr_rx_check_bench;
  localparam int TW = 10;
  logic clk = 0, rst_n = 0, start = 0, bit_vld = 0, bit_in = 0, err_clr = 0;
  logic [TW-1:0] tmo_long = 200, tmo_short = 100;
  logic hdr_ready, fmt_short, sfd_tmo, crc_err, len_ext, osc_locked;
  logic [7:0] sig_field, svc_field;
  logic [15:0] len_field;
  logic [1:0] rate;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  hdr_rx_check #(.TW(TW)) u_hdr_rx_check (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld), .bit_in(bit_in),
    .tmo_long(tmo_long), .tmo_short(tmo_short), .err_clr(err_clr),
    .hdr_ready(hdr_ready), .fmt_short(fmt_short), .sfd_tmo(sfd_tmo), .crc_err(crc_err),
    .sig_field(sig_field), .svc_field(svc_field), .len_field(len_field), .rate(rate),
    .len_ext(len_ext), .osc_locked(osc_locked));

  // {short, gap, sig, svc, len}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b0, 8'h0A, 8'h00, 16'h0123},
    {1'b1, 1'b0, 8'h14, 8'h04, 16'hBEEF},
    {1'b0, 1'b1, 8'h37, 8'h80, 16'h0010},
    {1'b1, 1'b1, 8'h6E, 8'h84, 16'hFFFF},
    {1'b0, 1'b0, 8'h55, 8'h7B, 16'h0000},
    {1'b1, 1'b0, 8'h6E, 8'hFF, 16'h8001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input logic [31:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic f = d[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (f) c = c ^ 16'h1021;
    end
    return ~c;
  endfunction

  function automatic logic [1:0] exp_rate(input logic [7:0] s);
    return s == 8'h14 ? 2'd1 : s == 8'h37 ? 2'd2 : s == 8'h6E ? 2'd3 : 2'd0;
  endfunction

  task automatic send(input logic b, input logic gap);
    if (gap) begin @(negedge clk); bit_vld = 0; bit_in = ~b; end
    @(negedge clk); bit_vld = 1; bit_in = b;
  endtask

  task automatic idle_edge();
    @(negedge clk); bit_vld = 0; start = 0; err_clr = 0;
  endtask

  task automatic arm();
    @(negedge clk); bit_vld = 0; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic frame(input logic sh, input logic gap, input int pre,
                       input logic [7:0] sg, input logic [7:0] sv, input logic [15:0] ln,
                       input logic bad);
    logic [15:0] sfd = sh ? 16'hF3A0 : 16'h05CF;
    logic [31:0] d = {ln, sv, sg};
    logic [15:0] c = crc_of(d) ^ (bad ? 16'h0001 : 16'h0000);
    for (int i = 0; i < pre; i++) send(~sh, gap);
    for (int i = 15; i >= 0; i--) send(sfd[i], gap);
    for (int i = 0; i < 32; i++) send(d[i], gap);
    for (int i = 15; i >= 0; i--) send(c[i], gap);
    idle_edge();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", hdr_ready, 0); chk("R1 err", crc_err, 0);
    chk("R1 tmo", sfd_tmo, 0); chk("R1 fmt", fmt_short, 0);
    chk("R1 len", len_field, 0); chk("R1 rate", rate, 0);
    rst_n = 1;

    foreach (VEC[k]) begin
      logic sh = VEC[k][33], gp = VEC[k][32];
      logic [7:0] sg = VEC[k][31:24], sv = VEC[k][23:16];
      logic [15:0] ln = VEC[k][15:0];
      arm();
      frame(sh, gp, 20, sg, sv, ln, 0);
      chk("R7 ready", hdr_ready, 1);
      chk("R3 fmt", fmt_short, sh);
      chk("R6 sig", sig_field, sg);
      chk("R6 svc", svc_field, sv);
      chk("R6 len", len_field, ln);
      chk("R10 rate", rate, exp_rate(sg));
      chk("R11 len_ext", len_ext, sv[7]);
      chk("R11 osc_locked", osc_locked, sv[2]);
      chk(gp ? "R12 gaps err" : "R8 no err", crc_err, 0);
    end

    arm();
    chk("R13 start clears ready", hdr_ready, 0);
    tmo_short = 30;
    for (int i = 0; i < 29; i++) send(0, 0);
    idle_edge();
    chk("R4 no tmo before limit", sfd_tmo, 0);
    send(0, 0);
    idle_edge();
    chk("R4 tmo at limit", sfd_tmo, 1);
    chk("R5 no err on tmo", crc_err, 0);
    idle_edge();
    chk("R4 tmo single pulse", sfd_tmo, 0);
    frame(1, 0, 4, 8'h0A, 8'h00, 16'h0042, 0);
    chk("R2 idle ignores frame", hdr_ready, 0);

    tmo_long = 40;
    arm();
    frame(0, 0, 24, 8'h14, 8'h00, 16'h0777, 0);
    chk("R4 sfd on limit bit accepted", hdr_ready, 1);
    chk("R4 sfd on limit len", len_field, 16'h0777);

    tmo_long = 200; tmo_short = 30;
    arm();
    frame(0, 0, 40, 8'h37, 8'h00, 16'h0100, 0);
    chk("R4 first bit picks long limit", hdr_ready, 1);

    arm();
    frame(1, 0, 10, 8'h6E, 8'h00, 16'h1234, 1);
    chk("R8 crc err set", crc_err, 1);
    chk("R8 ready low", hdr_ready, 0);
    chk("R8 fields kept", len_field, 16'h0100);
    frame(1, 0, 10, 8'h6E, 8'h00, 16'h1234, 0);
    chk("R8 back to idle", hdr_ready, 0);
    arm();
    frame(1, 0, 10, 8'h0A, 8'h04, 16'h0055, 0);
    chk("R9 err sticky", crc_err, 1);
    chk("R9 good frame ready", hdr_ready, 1);
    @(negedge clk); err_clr = 1;
    idle_edge();
    chk("R9 err cleared", crc_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule